// File: doc/BRIEF.md
# DDR SDRAM Address Mapper and Burst Sequencer

This block sits between a 32-bit core bus and a 16-bit DDR SDRAM data port. It splits each request address into chip-select, bank, row and column fields, with the row and column widths taken from a configuration register. It then emits the command requests needed to reach the addressed row. There are three cases. A row hit goes straight to the read or write. A closed bank gets an activate first. A bank with a different row open gets a precharge, then an activate. After the command it emits one beat descriptor per 16-bit transfer.

A line request moves 16 bytes as eight halfword beats. The first beat is the critical word, and the beats wrap inside the 16-byte line. A word request moves one 32-bit word as two beats. In every case the more significant halfword of each word comes first. The block keeps one open-row entry per chip select and bank, so page-mode hits skip activation.

Command spacing, refresh and the physical layer belong to other blocks. Here every command request lasts exactly one cycle, and beats follow back to back.

Top module: `sdram_map_burst`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid, beat_valid and cfg_err are 0, the mapping is 12 row bits, 8 column bits and one chip select, and every bank is closed.
- R2: A line request (req_line=1) yields 8 beats. With s = 2*addr[3:2], beat k has column {col[11:3], (s+k) mod 8}. beat_idx equals k, and beat_last is 1 only on beat 7.
- R3: A configuration write is accepted only when row bits are 12..14, column bits are 8..12 and their sum is at most 24. An accepted write clears cfg_err. A rejected write sets cfg_err to 1 and keeps the previous mapping.
- R4: The column is addr[C:1] (C = column bits), the bank is the next 2 bits, and the row is the next R bits. The chip select is the following bit when two chip selects are enabled, and 0 otherwise.
- R5: A request to a closed bank gives ACT (cs, bank, row) one cycle after acceptance, then the read/write command in the next cycle.
- R6: A request to a bank whose open row differs gives PRE, ACT and read/write in three consecutive cycles, starting one cycle after acceptance.
- R7: A request whose row is already open in its bank gives the read/write command one cycle after acceptance, with no PRE or ACT.
- R8: A word request (req_line=0) yields 2 beats, at columns {col[11:3], s} and {col[11:3], s+1}. req_ready is 0 from the cycle after acceptance through the last beat, and it is 1 again in the cycle after the last beat.
- R9: beat_hi is 1 on even beat indices, so the most significant halfword of each word comes first. The first beat follows the read/write command cycle directly.
- R10: An accepted configuration write closes every bank. A rejected write leaves the open rows unchanged.
- R11: cmd_kind is encoded PRE=0, ACT=1, RD=2, WR=3. The read/write command is WR when req_write=1 and RD otherwise. cmd_col is {col[11:3], s}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe (issued while idle) |
| cfg_row_bits | input | 4 | Requested row address width |
| cfg_col_bits | input | 4 | Requested column address width |
| cfg_two_cs | input | 1 | Enable second chip select |
| cfg_err | output | 1 | Last configuration write was rejected |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = 16-byte line, 0 = single 32-bit word |
| req_addr | input | 32 | Byte address |
| cmd_valid | output | 1 | Command request present |
| cmd_kind | output | 2 | PRE=0, ACT=1, RD=2, WR=3 |
| cmd_cs | output | 1 | Target chip select |
| cmd_bank | output | 2 | Target bank |
| cmd_row | output | 14 | Row for ACT |
| cmd_col | output | 12 | Start column for RD/WR |
| beat_valid | output | 1 | Beat descriptor present |
| beat_col | output | 12 | Halfword column of this beat |
| beat_idx | output | 3 | Beat number within the burst |
| beat_hi | output | 1 | Beat carries the upper halfword of a word |
| beat_last | output | 1 | Final beat of the burst |

## Verification
Acceptance happens on the edge where req_valid meets req_ready. The first command request appears in the cycle after that edge. A hit gives read/write in cycle 1 and beats from cycle 2. A closed bank gives ACT in cycle 1, read/write in cycle 2 and beats from cycle 3. A miss gives PRE, ACT and read/write in cycles 1 to 3. A configuration result appears in cfg_err one cycle after the write strobe. The bench drives inputs and samples outputs at falling edges, and it steps exactly one falling edge per cycle through the expected command path. Each cycle is therefore compared against the command or beat that is due in that cycle, and req_ready is checked in the cycle after the last beat.

// File: rtl/sdmb_pkg.sv
package sdmb_pkg;
    localparam int ADDR_W     = 32;
    localparam int ROW_MAX    = 14;
    localparam int COL_MAX    = 12;
    localparam int ROW_MIN    = 12;
    localparam int COL_MIN    = 8;
    localparam int SUM_MAX    = 24;
    localparam int BANK_W     = 2;
    localparam int NUM_CS     = 2;
    localparam int CS_W       = $clog2(NUM_CS);
    localparam int NUM_BANKS  = 1 << BANK_W;
    localparam int LINE_BEATS = 8;
    localparam int WORD_BEATS = 2;
    localparam int CNT_W      = $clog2(LINE_BEATS);
    localparam int CFG_W      = 4;
    localparam int IDX_W      = CS_W + BANK_W;

    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_RW,
        ST_BEAT
    } seq_st_e;

    typedef struct packed {
        logic [CFG_W-1:0] row_bits;
        logic [CFG_W-1:0] col_bits;
        logic             two_cs;
    } cfg_t;

    typedef struct packed {
        logic [CS_W-1:0]    cs;
        logic [BANK_W-1:0]  bank;
        logic [ROW_MAX-1:0] row;
        logic [COL_MAX-1:0] col;
    } dec_t;

    localparam cfg_t CFG_RESET = '{row_bits: CFG_W'(ROW_MIN),
                                   col_bits: CFG_W'(COL_MIN),
                                   two_cs:   1'b0};

    function automatic logic cfg_legal(cfg_t c);
        int r;
        int k;
        r = int'(c.row_bits);
        k = int'(c.col_bits);
        return (r >= ROW_MIN) && (r <= ROW_MAX) &&
               (k >= COL_MIN) && (k <= COL_MAX) &&
               ((r + k) <= SUM_MAX);
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(logic [CFG_W-1:0] n);
        return (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction
endpackage

// File: rtl/sdmb_cfg.sv
module sdmb_cfg
    import sdmb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cfg_t wr_cfg,
    output cfg_t cfg,
    output logic err,
    output logic accept
);
    cfg_t cfg_q;
    logic err_q;
    logic legal;

    assign legal  = cfg_legal(wr_cfg);
    assign accept = we && legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else if (we) begin
            if (legal) begin
                cfg_q <= wr_cfg;
                err_q <= 1'b0;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    assign cfg = cfg_q;
    assign err = err_q;

    // R3
    cfg_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_q.row_bits) + int'(cfg_q.col_bits) <= SUM_MAX) &&
        (cfg_q.row_bits >= CFG_W'(ROW_MIN)) && (cfg_q.col_bits >= CFG_W'(COL_MIN)));

    // R3
    reject_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !legal) |=> err_q && (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/sdmb_decode.sv
module sdmb_decode
    import sdmb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    output dec_t              dec
);
    logic [ADDR_W-1:0] hw_addr;
    logic [ADDR_W-1:0] past_col;
    logic [ADDR_W-1:0] past_bank;
    logic [ADDR_W-1:0] past_row;

    always_comb begin
        hw_addr   = addr >> 1;
        past_col  = hw_addr >> cfg.col_bits;
        past_bank = past_col >> BANK_W;
        past_row  = past_bank >> cfg.row_bits;
        dec.col   = COL_MAX'(hw_addr & low_mask(cfg.col_bits));
        dec.bank  = BANK_W'(past_col);
        dec.row   = ROW_MAX'(past_bank & low_mask(cfg.row_bits));
        dec.cs    = cfg.two_cs ? CS_W'(past_row) : '0;
    end
endmodule

// File: rtl/sdmb_bank_table.sv
module sdmb_bank_table
    import sdmb_pkg::*;
#(
    parameter int ENT_CS    = NUM_CS,
    parameter int ENT_BANKS = NUM_BANKS,
    parameter int ROW_W     = ROW_MAX,
    localparam int NUM_ENT  = ENT_CS * ENT_BANKS,
    localparam int TIDX_W   = $clog2(NUM_ENT)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              set,
    input  logic [TIDX_W-1:0] set_idx,
    input  logic [ROW_W-1:0]  set_row,
    input  logic [TIDX_W-1:0] lk_idx,
    output logic              lk_open,
    output logic [ROW_W-1:0]  lk_row
);
    logic [NUM_ENT-1:0] open_q;
    logic [ROW_W-1:0]   row_q [NUM_ENT];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            open_q <= '0;
        end else if (set) begin
            open_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set) begin
            row_q[set_idx] <= set_row;
        end
    end

    assign lk_open = open_q[lk_idx];
    assign lk_row  = row_q[lk_idx];

    // R7
    set_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (set && !clr) |=> open_q[$past(set_idx)] && (row_q[$past(set_idx)] == $past(set_row)));

    // R10
    clear_closes_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (open_q == '0));
endmodule

// File: rtl/sdmb_seq.sv
module sdmb_seq
    import sdmb_pkg::*;
#(
    parameter int BEATS_LINE = LINE_BEATS,
    parameter int BEATS_WORD = WORD_BEATS,
    localparam int BCNT_W    = $clog2(BEATS_LINE)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_line,
    input  dec_t                dec,
    input  logic                lk_open,
    input  logic [ROW_MAX-1:0]  lk_row,
    output logic                req_ready,
    output logic                cmd_valid,
    output cmd_e                cmd_kind,
    output dec_t                cmd_fld,
    output logic [COL_MAX-1:0]  cmd_col,
    output logic                beat_valid,
    output logic [COL_MAX-1:0]  beat_col,
    output logic [BCNT_W-1:0]   beat_idx,
    output logic                beat_hi,
    output logic                beat_last,
    output logic                tbl_set,
    output logic [IDX_W-1:0]    tbl_idx
);
    seq_st_e           state_q;
    dec_t              fld_q;
    logic              wr_q;
    logic              line_q;
    logic [BCNT_W-1:0] cnt_q;
    logic [BCNT_W-1:0] last_idx;
    logic [BCNT_W-1:0] start_lo;
    logic              hit;

    assign hit      = lk_open && (lk_row == dec.row);
    assign last_idx = line_q ? BCNT_W'(BEATS_LINE - 1) : BCNT_W'(BEATS_WORD - 1);
    assign start_lo = fld_q.col[BCNT_W-1:0] & ~BCNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fld_q   <= '0;
            wr_q    <= 1'b0;
            line_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        fld_q  <= dec;
                        wr_q   <= req_write;
                        line_q <= req_line;
                        if (hit)          state_q <= ST_RW;
                        else if (lk_open) state_q <= ST_PRE;
                        else              state_q <= ST_ACT;
                    end
                end
                ST_PRE:  state_q <= ST_ACT;
                ST_ACT:  state_q <= ST_RW;
                ST_RW: begin
                    cnt_q   <= '0;
                    state_q <= ST_BEAT;
                end
                ST_BEAT: begin
                    if (cnt_q == last_idx) state_q <= ST_IDLE;
                    else                   cnt_q   <= cnt_q + BCNT_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        cmd_valid  = (state_q == ST_PRE) || (state_q == ST_ACT) || (state_q == ST_RW);
        case (state_q)
            ST_PRE:  cmd_kind = CMD_PRE;
            ST_ACT:  cmd_kind = CMD_ACT;
            default: cmd_kind = wr_q ? CMD_WR : CMD_RD;
        endcase
        cmd_fld    = fld_q;
        cmd_col    = {fld_q.col[COL_MAX-1:BCNT_W], start_lo};
        beat_valid = (state_q == ST_BEAT);
        beat_idx   = cnt_q;
        beat_col   = {fld_q.col[COL_MAX-1:BCNT_W], BCNT_W'(start_lo + cnt_q)};
        beat_hi    = ~cnt_q[0];
        beat_last  = beat_valid && (cnt_q == last_idx);
        tbl_set    = (state_q == ST_ACT);
        tbl_idx    = {fld_q.cs, fld_q.bank};
    end

    // R6
    pre_then_act_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == CMD_PRE) |=> (cmd_valid && cmd_kind == CMD_ACT));

    // R5
    act_then_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == CMD_ACT) |=>
            (cmd_valid && (cmd_kind == CMD_RD || cmd_kind == CMD_WR)));

    // R9
    rw_then_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_kind == CMD_RD || cmd_kind == CMD_WR)) |=>
            (beat_valid && beat_idx == '0 && beat_hi));

    // R2
    beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=>
            (beat_valid &&
             beat_col[BCNT_W-1:0] == BCNT_W'($past(beat_col[BCNT_W-1:0]) + 1'b1) &&
             $stable(beat_col[COL_MAX-1:BCNT_W])));

    // R8
    ready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_last) |=> req_ready);

    // R8
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || beat_valid) |-> !req_ready);
endmodule

// File: rtl/sdram_map_burst.sv
module sdram_map_burst
    import sdmb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_W-1:0]      cfg_row_bits,
    input  logic [CFG_W-1:0]      cfg_col_bits,
    input  logic                  cfg_two_cs,
    output logic                  cfg_err,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_line,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  cmd_valid,
    output logic [1:0]            cmd_kind,
    output logic [CS_W-1:0]       cmd_cs,
    output logic [BANK_W-1:0]     cmd_bank,
    output logic [ROW_MAX-1:0]    cmd_row,
    output logic [COL_MAX-1:0]    cmd_col,
    output logic                  beat_valid,
    output logic [COL_MAX-1:0]    beat_col,
    output logic [CNT_W-1:0]      beat_idx,
    output logic                  beat_hi,
    output logic                  beat_last
);
    cfg_t               wr_cfg;
    cfg_t               cfg;
    logic               cfg_accept;
    dec_t               dec;
    dec_t               cmd_fld;
    cmd_e               kind;
    logic               lk_open;
    logic [ROW_MAX-1:0] lk_row;
    logic               tbl_set;
    logic [IDX_W-1:0]   tbl_idx;

    assign wr_cfg = '{row_bits: cfg_row_bits, col_bits: cfg_col_bits, two_cs: cfg_two_cs};

    sdmb_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg    (cfg),
        .err    (cfg_err),
        .accept (cfg_accept)
    );

    sdmb_decode u_dec (
        .addr (req_addr),
        .cfg  (cfg),
        .dec  (dec)
    );

    sdmb_bank_table u_tbl (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_accept),
        .set     (tbl_set),
        .set_idx (tbl_idx),
        .set_row (cmd_fld.row),
        .lk_idx  ({dec.cs, dec.bank}),
        .lk_open (lk_open),
        .lk_row  (lk_row)
    );

    sdmb_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_line   (req_line),
        .dec        (dec),
        .lk_open    (lk_open),
        .lk_row     (lk_row),
        .req_ready  (req_ready),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (kind),
        .cmd_fld    (cmd_fld),
        .cmd_col    (cmd_col),
        .beat_valid (beat_valid),
        .beat_col   (beat_col),
        .beat_idx   (beat_idx),
        .beat_hi    (beat_hi),
        .beat_last  (beat_last),
        .tbl_set    (tbl_set),
        .tbl_idx    (tbl_idx)
    );

    assign cmd_kind = kind;
    assign cmd_cs   = cmd_fld.cs;
    assign cmd_bank = cmd_fld.bank;
    assign cmd_row  = cmd_fld.row;
endmodule

// File: tb/sdram_map_burst_tb_top.sv
module sdram_map_burst_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_row_bits;
    logic [3:0]  cfg_col_bits;
    logic        cfg_two_cs;
    logic        cfg_err;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic        req_line;
    logic [31:0] req_addr;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic        cmd_cs;
    logic [1:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [11:0] cmd_col;
    logic        beat_valid;
    logic [11:0] beat_col;
    logic [2:0]  beat_idx;
    logic        beat_hi;
    logic        beat_last;

    int n_checks = 0;
    int n_errors = 0;
    int b_row = 12;
    int b_col = 8;
    int b_two = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdram_map_burst dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_row_bits(cfg_row_bits), .cfg_col_bits(cfg_col_bits),
        .cfg_two_cs(cfg_two_cs), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_line(req_line), .req_addr(req_addr),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_cs(cmd_cs),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .beat_valid(beat_valid), .beat_col(beat_col), .beat_idx(beat_idx),
        .beat_hi(beat_hi), .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] make_addr(int cs, int row, int bank, int col);
        longint a;
        a = (longint'(col) << 1) | (longint'(bank) << (1 + b_col)) |
            (longint'(row) << (3 + b_col)) | (longint'(cs) << (3 + b_col + b_row));
        return a[31:0];
    endfunction

    // path: 0 = open row hit, 1 = closed bank, 2 = different row open
    task automatic access(input int cs, input int row, input int bank, input int col,
                          input bit wr, input bit line, input int path, input string req);
        int upper;
        int slo;
        int nb;
        int exp_col;
        upper = col & ~7;
        slo   = (col & 7) & ~1;
        nb    = line ? 8 : 2;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_line  = line;
        req_addr  = make_addr(cs, row, bank, col);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8", "ready low after accept", req_ready, 0);
        if (path == 2) begin
            chk(cmd_valid && cmd_kind == 2'd0 && cmd_bank == bank[1:0] && cmd_cs == cs[0],
                "R6", "PRE cycle", {cmd_valid, cmd_kind, cmd_cs, cmd_bank},
                {1'b1, 2'd0, cs[0], bank[1:0]});
            @(negedge clk);
        end
        if (path >= 1) begin
            chk(cmd_valid && cmd_kind == 2'd1 && cmd_bank == bank[1:0] && cmd_cs == cs[0] &&
                cmd_row == row[13:0],
                path == 2 ? "R6" : "R5", "ACT cycle (R4 fields)",
                {cmd_valid, cmd_kind, cmd_cs, cmd_bank, cmd_row},
                {1'b1, 2'd1, cs[0], bank[1:0], row[13:0]});
            @(negedge clk);
        end
        chk(cmd_valid && cmd_kind == (wr ? 2'd3 : 2'd2) && cmd_col == 12'(upper | slo) &&
            cmd_bank == bank[1:0] && cmd_cs == cs[0],
            path == 0 ? "R7" : "R11", "RD/WR cycle",
            {cmd_valid, cmd_kind, cmd_cs, cmd_bank, cmd_col},
            {1'b1, wr ? 2'd3 : 2'd2, cs[0], bank[1:0], 12'(upper | slo)});
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            exp_col = upper | ((slo + k) & 7);
            chk(beat_valid && !cmd_valid && beat_col == 12'(exp_col) && beat_idx == 3'(k),
                line ? "R2" : "R8", "beat column/index",
                {beat_valid, beat_col, beat_idx}, {1'b1, 12'(exp_col), 3'(k)});
            chk(beat_hi == ((k % 2) == 0) && beat_last == (k == nb - 1),
                "R9", "beat hi/last", {beat_hi, beat_last},
                {((k % 2) == 0), (k == nb - 1)});
        end
        @(negedge clk);
        chk(req_ready && !beat_valid && !cmd_valid, "R8", "ready after last beat",
            {req_ready, beat_valid, cmd_valid}, 3'b100);
    endtask

    task automatic cfg_write(input int r, input int c, input int two, input bit exp_err,
                             input string req);
        @(negedge clk);
        cfg_we       = 1'b1;
        cfg_row_bits = 4'(r);
        cfg_col_bits = 4'(c);
        cfg_two_cs   = two[0];
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_err == exp_err, req, "cfg_err after write", cfg_err, exp_err);
        if (!exp_err) begin
            b_row = r;
            b_col = c;
            b_two = two;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !cmd_valid && !beat_valid && !cfg_err, "R1", "idle after reset",
            {req_ready, cmd_valid, beat_valid, cfg_err}, 4'b1000);
    endtask

    task automatic t_page_paths;
        // R1 banks closed, default 12/8 mapping
        access(0, 'h123, 2, 'h35, 1'b0, 1'b1, 1, "R5");
        access(0, 'h123, 2, 'h0A, 1'b1, 1'b1, 0, "R7");
        access(0, 'h456, 2, 'h07, 1'b0, 1'b1, 2, "R6");
        access(0, 'h456, 1, 'h13, 1'b0, 1'b0, 1, "R8");
        access(0, 'h456, 1, 'h1C, 1'b1, 1'b0, 0, "R8");
    endtask

    task automatic t_cfg_reject;
        cfg_write(14, 12, 0, 1'b1, "R3");
        // R10: rejected write keeps bank 2 row open, old mapping used
        access(0, 'h456, 2, 'h02, 1'b0, 1'b1, 0, "R10");
        cfg_write(11, 8, 0, 1'b1, "R3");
        cfg_write(14, 13, 0, 1'b1, "R3");
    endtask

    task automatic t_cfg_accept;
        cfg_write(13, 10, 1, 1'b0, "R3");
        // R10: all banks closed after accepted write; R4 with cs bit
        access(1, 'h456, 2, 'h155, 1'b0, 1'b1, 1, "R10");
        access(0, 'h456, 2, 'h155, 1'b1, 1'b1, 1, "R4");
        access(1, 'h1FFF, 2, 'h3FF, 1'b0, 1'b1, 2, "R4");
        access(1, 'h1FFF, 2, 'h200, 1'b1, 1'b0, 0, "R7");
    endtask

    initial begin
        rst = 1'b1;
        cfg_we = 1'b0;
        cfg_row_bits = 4'd12;
        cfg_col_bits = 4'd8;
        cfg_two_cs = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_line = 1'b0;
        req_addr = '0;
        t_reset();
        t_page_paths();
        t_cfg_reject();
        t_cfg_accept();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule